// File: doc/BRIEF.md
# Key-Guarded Configuration Register File

This block is the configuration register file of a power-management controller. A host reaches it over a simple synchronous register bus: one address, one write strobe with write data, one read strobe, and a registered read-data return. Byte addresses and data are both 8 bits. The file holds three kinds of location:

- a fixed identification byte;
- a window of status bytes that live hardware logic drives into the block;
- general read/write storage.

A fixed set of storage locations holds output-voltage settings and their limits. These locations change only while a key register is open. Writing the key byte to that register opens it. Writing any other byte closes it again. A guarded write that arrives while the key register is closed changes nothing, and the block signals the rejection with a one-cycle error flag. All stored bits read back exactly as written, so a host can change one field safely by reading the whole byte, merging the field under a mask and writing the byte back.

The key logic is a two-state machine with `LK_SHUT` (closed, the reset state) and `LK_OPEN` (open). The transition `LK_SHUT -> LK_OPEN` happens on a write of the key byte to the key register. The transition `LK_OPEN -> LK_SHUT` happens on a write of any other byte to the key register. Every other cycle, the machine holds its state.

Top module: `cfg_keyreg_file`

## Requirements
- R1: After reset, the key register is closed, `rd_data` is 0x00, `wr_reject` is 0, and every storage byte reads 0x00.
- R2: A read of address 0x01 returns the identification byte, whose upper nibble is 0xB (default 0xB3). Writes to 0x01 are ignored.
- R3: A read of address 0x02+k (k = 0..5) returns the live byte `status_in[8k+7:8k]` as sampled at the read strobe's clock edge. Writes to 0x02–0x07 are ignored.
- R4: Unguarded storage addresses in 0x08–0x4D accept writes at any time, and all 8 written bits read back unchanged.
- R5: Writing 0x5C to address 0x4E opens the key register. A read of 0x4E returns 0x01 while it is open and 0x00 while it is closed. The key register changes only on writes to 0x4E.
- R6: Writing any value other than 0x5C to 0x4E, including 0x00, closes the key register.
- R7: A write to a guarded address (0x11, 0x15, 0x1F, 0x20, 0x22, 0x2F, 0x36, 0x38, 0x39, 0x3C) while the key register is closed leaves the stored byte unchanged. It also drives `wr_reject` high for exactly the one cycle after the write strobe.
- R8: A write to a guarded address while the key register is open takes effect, and `wr_reject` stays low.
- R9: Address 0x00 and addresses above 0x4E read as 0x00, and writes to them have no effect.
- R10: `rd_data` changes one clock after a read strobe and then holds until the next read strobe. A read and a write to the same address in the same cycle return the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| wr_reject | output | 1 | One-cycle pulse: a guarded write was refused |
| status_in | input | 48 | Six live status bytes; byte k belongs to address 0x02+k |

## Verification
The bench builds the block with its default parameters:

- a six-byte status window;
- storage from 0x08 to 0x4D;
- the key register at 0x4E;
- key byte 0x5C;
- identification byte 0xB3.

With these values, every guarded address can be struck both while the key register is closed and while it is open. Every storage byte can be swept and read back. The edges of the status window, address 0x00, and addresses past the key register all fall within a short run. A behavioural model predicts `rd_data` and `wr_reject` on every clock, including after keys that miss by one bit.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    // Key register state
    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_state_e;

    // Address classes produced by the decoder
    typedef enum logic [2:0] {
        AC_NONE    = 3'd0,
        AC_IDENT   = 3'd1,
        AC_STATUS  = 3'd2,
        AC_PLAIN   = 3'd3,
        AC_GUARDED = 3'd4,
        AC_KEY     = 3'd5
    } addr_class_e;

    localparam int GUARD_N = 10;
    // Guarded storage addresses (voltage settings and limits)
    localparam logic [GUARD_N*8-1:0] GUARD_SET = {
        8'h11, 8'h15, 8'h1F, 8'h20, 8'h22,
        8'h2F, 8'h36, 8'h38, 8'h39, 8'h3C
    };

    function automatic logic is_guarded(input logic [7:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < GUARD_N; i++) begin
            if (GUARD_SET[i*8 +: 8] == a) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/cfgkey_decode.sv
module cfgkey_decode
    import cfgkey_pkg::*;
#(
    parameter int AW          = 8,
    parameter int IDENT_ADDR  = 1,
    parameter int STAT_FIRST  = 2,
    parameter int STAT_LAST   = 7,
    parameter int STORE_FIRST = 8,
    parameter int LOCK_ADDR   = 78
) (
    input  logic [AW-1:0] addr,
    output addr_class_e   cls
);
    int a;

    always_comb begin
        a = int'(addr);
        if (a == IDENT_ADDR) begin
            cls = AC_IDENT;
        end else if (a >= STAT_FIRST && a <= STAT_LAST) begin
            cls = AC_STATUS;
        end else if (a == LOCK_ADDR) begin
            cls = AC_KEY;
        end else if (a >= STORE_FIRST && a < LOCK_ADDR) begin
            cls = is_guarded(8'(addr)) ? AC_GUARDED : AC_PLAIN;
        end else begin
            cls = AC_NONE;
        end
    end
endmodule

// File: rtl/cfgkey_lock_fsm.sv
module cfgkey_lock_fsm
    import cfgkey_pkg::*;
#(
    parameter int             DW  = 8,
    parameter logic [DW-1:0]  KEY = 8'h5C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_val,
    output logic          unlocked
);
    lock_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_wr && key_val == KEY) state_d = LK_OPEN;
            LK_OPEN: if (key_wr && key_val != KEY) state_d = LK_SHUT;
            default: state_d = LK_SHUT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unlocked = (state_q == LK_OPEN);
    end

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY) |=> unlocked);                  // R5
    AST_OTHER_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val != KEY) |=> !unlocked);                 // R6
    AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(unlocked));                            // R5
endmodule

// File: rtl/cfgkey_bank.sv
module cfgkey_bank #(
    parameter int DW    = 8,
    parameter int AW    = 8,
    parameter int FIRST = 8,
    parameter int LAST  = 77
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int NSTORE = LAST - FIRST + 1;

    logic [NSTORE*DW-1:0] flat;

    for (genvar g = 0; g < NSTORE; g++) begin : g_cell
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                  q <= '0;
            else if (we && int'(waddr) == FIRST + g)     q <= wdata;
        end
        assign flat[g*DW +: DW] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSTORE; i++) begin
            if (int'(raddr) == FIRST + i) rdata = flat[i*DW +: DW];
        end
    end

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flat));                                    // R7
endmodule

// File: rtl/cfg_keyreg_file.sv
module cfg_keyreg_file
    import cfgkey_pkg::*;
#(
    parameter int            DW          = 8,
    parameter int            AW          = 8,
    parameter int            STAT_FIRST  = 2,
    parameter int            STAT_LAST   = 7,
    parameter int            STORE_FIRST = 8,
    parameter int            LOCK_ADDR   = 78,
    parameter logic [DW-1:0] KEY         = 8'h5C,
    parameter logic [DW-1:0] DEV_ID      = 8'hB3
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic                                      rd_en,
    input  logic [AW-1:0]                             addr,
    input  logic [DW-1:0]                             wr_data,
    output logic [DW-1:0]                             rd_data,
    output logic                                      wr_reject,
    input  logic [(STAT_LAST-STAT_FIRST+1)*DW-1:0]    status_in
);
    localparam int NSTAT      = STAT_LAST - STAT_FIRST + 1;
    localparam int STORE_LAST = LOCK_ADDR - 1;

    addr_class_e   cls;
    logic          unlocked;
    logic          bank_we;
    logic          key_wr;
    logic [DW-1:0] bank_rdata;
    logic [DW-1:0] stat_byte;
    logic [DW-1:0] rd_next;

    cfgkey_decode #(
        .AW(AW), .IDENT_ADDR(1), .STAT_FIRST(STAT_FIRST), .STAT_LAST(STAT_LAST),
        .STORE_FIRST(STORE_FIRST), .LOCK_ADDR(LOCK_ADDR)
    ) u_decode (
        .addr(addr),
        .cls (cls)
    );

    assign key_wr = wr_en && (cls == AC_KEY);

    cfgkey_lock_fsm #(.DW(DW), .KEY(KEY)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (wr_data),
        .unlocked(unlocked)
    );

    assign bank_we = wr_en && ((cls == AC_PLAIN) || (cls == AC_GUARDED && unlocked));

    cfgkey_bank #(.DW(DW), .AW(AW), .FIRST(STORE_FIRST), .LAST(STORE_LAST)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bank_we),
        .waddr(addr),
        .wdata(wr_data),
        .raddr(addr),
        .rdata(bank_rdata)
    );

    // Live status byte selection
    always_comb begin
        stat_byte = '0;
        for (int k = 0; k < NSTAT; k++) begin
            if (int'(addr) == STAT_FIRST + k) stat_byte = status_in[k*DW +: DW];
        end
    end

    // Read source by address class
    always_comb begin
        unique case (cls)
            AC_IDENT:               rd_next = DEV_ID;
            AC_STATUS:              rd_next = stat_byte;
            AC_PLAIN, AC_GUARDED:   rd_next = bank_rdata;
            AC_KEY:                 rd_next = {{(DW-1){1'b0}}, unlocked};
            default:                rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            wr_reject <= 1'b0;
        end else begin
            if (rd_en) rd_data <= rd_next;
            wr_reject <= wr_en && (cls == AC_GUARDED) && !unlocked;
        end
    end

    AST_REJECT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cls == AC_GUARDED && !unlocked) |=> wr_reject);  // R7
    AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en));                               // R7
    AST_GUARD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cls == AC_GUARDED && unlocked) |=> !wr_reject);  // R8
    AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cls == AC_IDENT) |=> rd_data == DEV_ID);         // R2
    AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cls == AC_NONE) |=> rd_data == '0);              // R9
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));                              // R10
endmodule

// File: tb/tb_cfg_keyreg_file.sv
module tb_cfg_keyreg_file;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [7:0]  addr, wr_data;
    logic [7:0]  rd_data;
    logic        wr_reject;
    logic [47:0] status_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    int       mdl_mem [256];
    bit       mdl_open;
    logic [7:0] exp_rd;
    bit       exp_rej;
    int       gq[$] = '{8'h3C, 8'h39, 8'h38, 8'h36, 8'h2F, 8'h22, 8'h20, 8'h1F, 8'h15, 8'h11};

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_keyreg_file dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .wr_reject(wr_reject), .status_in(status_in)
    );

    function automatic bit mdl_guard(int a);
        foreach (gq[i]) if (gq[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] mdl_read(int a);
        if (a == 1)              return 8'hB3;
        if (a >= 2 && a <= 7)    return status_in[(a-2)*8 +: 8];
        if (a == 78)             return mdl_open ? 8'h01 : 8'h00;
        if (a >= 8 && a <= 77)   return 8'(mdl_mem[a]);
        return 8'h00;
    endfunction

    task automatic compare(input string tag);
        n_cmp++;
        if (rd_data !== exp_rd || wr_reject !== exp_rej) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h wr_reject=%0b expected rd_data=%02h wr_reject=%0b",
                     tag, rd_data, wr_reject, exp_rd, exp_rej);
        end
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic op(input bit we, input bit re, input int a, input int d, input string tag);
        wr_en = we; rd_en = re; addr = 8'(a); wr_data = 8'(d);
        @(posedge clk);
        if (re) exp_rd = mdl_read(a);
        exp_rej = we && mdl_guard(a) && !mdl_open;
        if (we) begin
            if (a == 78)                                            mdl_open = (d == 8'h5C);
            else if (a >= 8 && a <= 77 && (!mdl_guard(a) || mdl_open)) mdl_mem[a] = d;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        compare(tag);
    endtask

    task automatic wr(input int a, input int d, input string tag); op(1, 0, a, d, tag); endtask
    task automatic rd(input int a, input string tag);              op(0, 1, a, 0, tag); endtask

    initial begin
        rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
        status_in = 48'h0;
        foreach (mdl_mem[i]) mdl_mem[i] = 0;
        mdl_open = 0; exp_rd = 0; exp_rej = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        rd(8'h0A, "R1");
        rd(8'h11, "R1");
        rd(8'h4E, "R1");

        // Identification
        rd(8'h01, "R2");
        wr(8'h01, 8'h00, "R2");
        rd(8'h01, "R2");

        // Live status window
        status_in = 48'hA1B2C3D4E5F6;
        rd(8'h02, "R3");
        rd(8'h07, "R3");
        wr(8'h03, 8'h99, "R3");
        rd(8'h03, "R3");
        status_in = 48'h0F1E2D3C4B5A;
        rd(8'h03, "R3");
        rd(8'h06, "R3");

        // Unguarded storage, field merge
        wr(8'h0A, 8'hA5, "R4");
        wr(8'h4D, 8'h3C, "R4");
        wr(8'h08, 8'hFF, "R4");
        rd(8'h0A, "R4");
        wr(8'h0A, (8'hA5 & 8'hF0) | 8'h03, "R4");
        rd(8'h0A, "R4");
        rd(8'h4D, "R4");
        rd(8'h08, "R4");

        // Guarded writes while closed
        foreach (gq[i]) begin
            wr(gq[i], 8'h55 + i, "R7");
            op(0, 0, 0, 0, "R7");
            rd(gq[i], "R7");
        end

        // Open and write guarded registers
        wr(8'h4E, 8'h5C, "R5");
        rd(8'h4E, "R5");
        wr(8'h0C, 8'h12, "R5");
        rd(8'h4E, "R5");
        foreach (gq[i]) begin
            wr(gq[i], 8'hC0 + i, "R8");
            rd(gq[i], "R8");
        end

        // Near-miss key closes
        wr(8'h4E, 8'h5D, "R6");
        rd(8'h4E, "R6");
        wr(8'h15, 8'h77, "R6");
        rd(8'h15, "R6");
        wr(8'h4E, 8'h5C, "R5");
        wr(8'h4E, 8'h5C, "R5");
        rd(8'h4E, "R5");
        wr(8'h4E, 8'h00, "R6");
        rd(8'h4E, "R6");
        wr(8'h39, 8'h01, "R7");
        rd(8'h39, "R7");

        // Unimplemented addresses
        rd(8'h00, "R9");
        wr(8'h4F, 8'hEE, "R9");
        rd(8'h4F, "R9");
        wr(8'hFF, 8'hEE, "R9");
        rd(8'hFF, "R9");
        wr(8'h00, 8'h5C, "R9");
        rd(8'h4E, "R9");

        // Registered read timing and same-cycle read/write
        rd(8'h4D, "R10");
        op(0, 0, 8'h4D, 0, "R10");
        op(0, 0, 8'h01, 0, "R10");
        op(1, 1, 8'h4D, 8'h81, "R10");
        rd(8'h4D, "R10");

        // Full sweep with key open
        wr(8'h4E, 8'h5C, "R8");
        for (int a = 8; a <= 77; a++) wr(a, a ^ 8'h5A, "R4");
        for (int a = 8; a <= 77; a++) rd(a, "R4");
        wr(8'h4E, 8'h00, "R6");
        for (int a = 8; a <= 77; a++) wr(a, 8'h00, "R7");
        for (int a = 8; a <= 77; a++) rd(a, "R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule